// File: doc/BRIEF.md
# Lockable GPIO Port Register Bank

This block is the register front end for one port of sixteen general-purpose pins. Software reaches it over a plain 32-bit word bus: an address, a write strobe, a read strobe and write data. Every access completes in one cycle, so the bus has no back-pressure and no handshake. Write data is taken as a full word, and read data appears on the cycle after the read strobe. The bank holds four per-pin configuration fields (direction mode, driver type, slew grade, pull selection). It also holds an output latch, an input register fed from pad inputs through a two-flop synchronizer, and a write-only set/clear register that changes single output bits without a read-modify-write.

The configuration of selected pins can be frozen. Software arms the freeze with a fixed series of accesses to the lock register: a write with the key bit high, a write with the key bit low, a write with the key bit high again, all carrying the same pin mask, and then a read. After the read, the masked pins ignore every write to their configuration fields until reset. The output latch stays writable. From the registers the block derives the pad controls: drive value, drive enable, open-drain flag, pull-up, pull-down and slew grade.

Word map (word address on `bus_addr`): 0 mode, 1 driver type, 2 slew, 3 pull, 4 input data, 5 output data, 6 set/clear, 7 lock. All other addresses read zero and ignore writes.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset every register reads zero. All `pad_oe`, `pad_pu`, `pad_pd` and `pad_out` bits are 0, so every pin starts as an undriven input with no pull.
- R2: The configuration words store written data and read it back on the cycle after a read strobe. Mode (2 bits per pin at bits 2n+1:2n): 00 input, 01 general output, 10 alternate, 11 analog. Slew (2 bits per pin): 00 slowest to 11 fastest. Pull (2 bits per pin): 00 none, 01 up, 10 down, 11 reserved. Driver type (bit n): 0 push-pull, 1 open-drain, with bits 31:16 reading zero.
- R3: `pad_out[n]` follows output bit n and `pad_od[n]` follows driver-type bit n. `pad_oe[n]` is 1 only when pin n's mode is 01 and it is either push-pull or has output bit n at 0. `pad_pu[n]` is 1 for pull code 01 and `pad_pd[n]` is 1 for code 10. Code 11 drives neither.
- R4: The output data word stores bits 15:0 of a write, and its bits 31:16 read zero.
- R5: A write to the set/clear word sets output bit n when data bit n is 1 and clears it when data bit n+16 is 1. Bits written as 0 leave their output bits unchanged. Reading the set/clear word returns zero.
- R6: When one write to the set/clear word has both the set bit and the clear bit of a pin at 1, the pin ends at 1.
- R7: The input data word shows pad inputs after two clock edges of synchronization. A read issued one cycle after a pad change returns the old value, and the next read returns the new one. Its bits 31:16 read zero, and writes to it have no effect.
- R8: The lock word reads the mask in bits 15:0 and the active flag in bit 16. The flag becomes 1 after this series: a write with bit 16=1 and mask M, a write with bit 16=0 and mask M, a write with bit 16=1 and mask M, then a read of the lock word. That final read still returns flag 0, and later reads return 1. After that the flag stays 1 until reset.
- R9: While the lock is active, writes to the mode, driver-type, slew and pull fields of masked pins, and writes to the lock word, are ignored. Unmasked pins and the output and set/clear words stay writable.
- R10: A mask differing from the first write's, a key bit out of order, or a read before the third write returns the series to its start, leaving the flag 0. A write with bit 16=1 always starts a new series.
- R11: Read data is captured only on a read strobe and holds until the next one. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Word address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| pad_in | input | 16 | Asynchronous pad inputs |
| pad_out | output | 16 | Pad drive values |
| pad_oe | output | 16 | Pad drive enables |
| pad_od | output | 16 | Open-drain select per pin |
| pad_pu | output | 16 | Pull-up enable per pin |
| pad_pd | output | 16 | Pull-down enable per pin |
| pad_speed | output | 32 | Slew grade, 2 bits per pin |

## Verification
The hardest state to reach from the ports is an active lock, together with the aborted series that must not produce one. Both depend on an exact order of bus writes and a closing read, and nothing shows at the pads until the lock is active. The bench drives a series that breaks on a mismatched mask, then one that reads too early, and confirms each time that the flag stays 0 and that a pin field can still be written. It then completes the full series and watches the flag appear one read late. Finally it writes all-ones to the mode and driver-type words and checks that only the masked pins kept their old values.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [3:0] {
    A_MODE   = 4'd0,
    A_OTYPE  = 4'd1,
    A_SPEED  = 4'd2,
    A_PULL   = 4'd3,
    A_IDR    = 4'd4,
    A_ODR    = 4'd5,
    A_SETCLR = 4'd6,
    A_LOCK   = 4'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    LK_IDLE = 2'd0,
    LK_ARM1 = 2'd1,
    LK_ARM2 = 2'd2,
    LK_ARM3 = 2'd3
  } lk_state_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/gpio_cfg_field.sv
module gpio_cfg_field #(
  parameter int NPINS = 16,
  parameter int FW    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [NPINS*FW-1:0] wdata,
  input  logic [NPINS-1:0]    frozen,
  output logic [NPINS*FW-1:0] q
);
  logic [FW-1:0] fld [NPINS];

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    always_ff @(posedge clk) begin
      if (!rst_n)                fld[p] <= '0;
      else if (we && !frozen[p]) fld[p] <= wdata[p*FW +: FW];
    end
    assign q[p*FW +: FW] = fld[p];
  end
endmodule

// File: rtl/gpio_lock_ctrl.sv
module gpio_lock_ctrl
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic             rd_hit,
  input  logic             key,
  input  logic [NPINS-1:0] wmask,
  output logic             active,
  output logic [NPINS-1:0] mask
);
  lk_state_e st;
  logic      same;

  assign same = (wmask == mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= LK_IDLE;
      active <= 1'b0;
      mask   <= '0;
    end else if (!active) begin
      if (wr_hit) begin
        mask <= wmask;
        unique case (st)
          LK_ARM1: st <= (!key && same) ? LK_ARM2 : (key ? LK_ARM1 : LK_IDLE);
          LK_ARM2: st <= ( key && same) ? LK_ARM3 : LK_IDLE;
          default: st <= key ? LK_ARM1 : LK_IDLE;
        endcase
        if (st == LK_ARM2 && key && !same) st <= LK_ARM1;
      end else if (rd_hit) begin
        if (st == LK_ARM3) active <= 1'b1;
        st <= LK_IDLE;
      end
    end
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 16,
  parameter int DW    = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3:0]         bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  input  logic [NPINS-1:0]   pad_in,
  output logic [NPINS-1:0]   pad_out,
  output logic [NPINS-1:0]   pad_oe,
  output logic [NPINS-1:0]   pad_od,
  output logic [NPINS-1:0]   pad_pu,
  output logic [NPINS-1:0]   pad_pd,
  output logic [2*NPINS-1:0] pad_speed
);
  localparam int HALF = DW / 2;
  localparam int W2   = 2 * NPINS;

  logic [W2-1:0]    mode_q, speed_q, pull_q;
  logic [NPINS-1:0] otype_q, odr_q, idr_q;
  logic [NPINS-1:0] lock_mask, frozen;
  logic             lock_active;
  logic [DW-1:0]    rd_mux, lock_word;
  logic [NPINS-1:0] set_bits, clr_bits;

  assign frozen = lock_active ? lock_mask : '0;

  gpio_cfg_field #(.NPINS(NPINS), .FW(2)) u_mode (
    .clk(clk), .rst_n(rst_n), .we(bus_wr && bus_addr == A_MODE),
    .wdata(bus_wdata[W2-1:0]), .frozen(frozen), .q(mode_q));
  gpio_cfg_field #(.NPINS(NPINS), .FW(1)) u_otype (
    .clk(clk), .rst_n(rst_n), .we(bus_wr && bus_addr == A_OTYPE),
    .wdata(bus_wdata[NPINS-1:0]), .frozen(frozen), .q(otype_q));
  gpio_cfg_field #(.NPINS(NPINS), .FW(2)) u_speed (
    .clk(clk), .rst_n(rst_n), .we(bus_wr && bus_addr == A_SPEED),
    .wdata(bus_wdata[W2-1:0]), .frozen(frozen), .q(speed_q));
  gpio_cfg_field #(.NPINS(NPINS), .FW(2)) u_pull (
    .clk(clk), .rst_n(rst_n), .we(bus_wr && bus_addr == A_PULL),
    .wdata(bus_wdata[W2-1:0]), .frozen(frozen), .q(pull_q));

  gpio_in_sync #(.W(NPINS), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(idr_q));

  gpio_lock_ctrl #(.NPINS(NPINS)) u_lock (
    .clk(clk), .rst_n(rst_n),
    .wr_hit(bus_wr && bus_addr == A_LOCK),
    .rd_hit(bus_rd && bus_addr == A_LOCK),
    .key(bus_wdata[HALF]), .wmask(bus_wdata[NPINS-1:0]),
    .active(lock_active), .mask(lock_mask));

  // Output latch: a set bit is applied after the clear, so set wins.
  assign set_bits = bus_wdata[NPINS-1:0];
  assign clr_bits = bus_wdata[HALF +: NPINS];

  always_ff @(posedge clk) begin
    if (!rst_n)                               odr_q <= '0;
    else if (bus_wr && bus_addr == A_ODR)     odr_q <= bus_wdata[NPINS-1:0];
    else if (bus_wr && bus_addr == A_SETCLR)  odr_q <= (odr_q & ~clr_bits) | set_bits;
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pad
    logic [1:0] md, pl;
    assign md        = mode_q[2*p +: 2];
    assign pl        = pull_q[2*p +: 2];
    assign pad_oe[p] = (md == 2'b01) && (!otype_q[p] || !odr_q[p]);
    assign pad_pu[p] = (pl == 2'b01);
    assign pad_pd[p] = (pl == 2'b10);
  end

  assign pad_out   = odr_q;
  assign pad_od    = otype_q;
  assign pad_speed = speed_q;

  always_comb begin
    lock_word              = '0;
    lock_word[NPINS-1:0]   = lock_mask;
    lock_word[HALF]        = lock_active;
    unique case (bus_addr)
      A_MODE:  rd_mux = DW'(mode_q);
      A_OTYPE: rd_mux = DW'(otype_q);
      A_SPEED: rd_mux = DW'(speed_q);
      A_PULL:  rd_mux = DW'(pull_q);
      A_IDR:   rd_mux = DW'(idr_q);
      A_ODR:   rd_mux = DW'(odr_q);
      A_LOCK:  rd_mux = lock_word;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 16,
  parameter int DW    = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [3:0]         bus_addr,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [DW-1:0]      bus_wdata,
  input logic [DW-1:0]      bus_rdata,
  input logic [NPINS-1:0]   pad_out,
  input logic               lock_active,
  input logic [NPINS-1:0]   lock_mask,
  input logic [2*NPINS-1:0] mode_q
);
  localparam int HALF = DW / 2;

  a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock_active |=> lock_active);

  a_r9_mask_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    lock_active |=> $stable(lock_mask));

  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr == A_ODR || bus_addr == A_IDR)) |=> bus_rdata[DW-1:HALF] == '0);

  for (genvar p = 0; p < NPINS; p++) begin : g_chk
    a_r9_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_active && lock_mask[p]) |=> $stable(mode_q[2*p +: 2]));

    a_r6_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_SETCLR && bus_wdata[p]) |=> pad_out[p]);

    a_r5_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_SETCLR && !bus_wdata[p] && bus_wdata[HALF+p]) |=> !pad_out[p]);
  end
endmodule

bind gpio_port_regs gpio_port_regs_chk #(.NPINS(NPINS), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_out(pad_out),
  .lock_active(lock_active), .lock_mask(lock_mask), .mode_q(mode_q));

// File: tb/test_gpio_port_regs.sv
module test_gpio_port_regs;
  localparam int CLK_NS = 10;
  localparam int NV     = 8;
  // {addr, write data, expected read}
  localparam logic [67:0] VEC [NV] = '{
    {4'd0, 32'h5555_5555, 32'h5555_5555},
    {4'd1, 32'hFFFF_0F0F, 32'h0000_0F0F},
    {4'd2, 32'hA5C3_1E87, 32'hA5C3_1E87},
    {4'd3, 32'h1B1B_E4E4, 32'h1B1B_E4E4},
    {4'd5, 32'hDEAD_BEEF, 32'h0000_BEEF},
    {4'd6, 32'h0000_0001, 32'h0000_0000},
    {4'd4, 32'hFFFF_FFFF, 32'h0000_0000},
    {4'd9, 32'h0000_1234, 32'h0000_0000}
  };

  logic        clk = 0, rst_n = 0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [15:0] pad_in = '0, pad_out, pad_oe, pad_od, pad_pu, pad_pd;
  logic [31:0] pad_speed;
  int          total = 0, bad = 0;
  bit          done = 0;

  always #(CLK_NS/2) clk = ~clk;

  gpio_port_regs i_gpio_port_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_od(pad_od), .pad_pu(pad_pu), .pad_pd(pad_pd),
    .pad_speed(pad_speed));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 pad_oe", {16'h0, pad_oe}, 32'h0);
    check("R1 pulls", {pad_pu, pad_pd}, 32'h0);
    check("R1 pad_out", {16'h0, pad_out}, 32'h0);
    rd(4'd0, r); check("R1 mode", r, 32'h0);
    rd(4'd7, r); check("R1 lock", r, 32'h0);

    // Vector walk: R2, R4, R5, R7, R11
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][67:64], VEC[i][63:32]);
      rd(VEC[i][67:64], r);
      check($sformatf("R2/R4/R5/R7/R11 vec%0d", i), r, VEC[i][31:0]);
    end
    check("R2 speed pads", pad_speed, 32'hA5C3_1E87);
    rd(4'd9, r);
    wr(4'd0, 32'hFFFF_FFFF);
    check("R11 rdata held", bus_rdata, 32'h0);

    // R3 pad controls
    wr(4'd0, 32'h0000_0010); wr(4'd1, 32'h0); wr(4'd3, 32'h0); wr(4'd5, 32'h0004);
    check("R3 oe push-pull", {16'h0, pad_oe}, 32'h0004);
    check("R3 out", {16'h0, pad_out}, 32'h0004);
    wr(4'd1, 32'h0004);
    check("R3 od high off", {16'h0, pad_oe}, 32'h0);
    check("R3 od flag", {16'h0, pad_od}, 32'h0004);
    wr(4'd5, 32'h0);
    check("R3 od low drives", {16'h0, pad_oe}, 32'h0004);
    wr(4'd3, 32'h40); check("R3 pull up", {pad_pu, pad_pd}, 32'h0008_0000);
    wr(4'd3, 32'h80); check("R3 pull down", {pad_pu, pad_pd}, 32'h0000_0008);
    wr(4'd3, 32'hC0); check("R3 pull reserved", {pad_pu, pad_pd}, 32'h0);

    // R5 / R6 set-clear
    wr(4'd6, 32'h0000_0005); rd(4'd5, r); check("R5 set", r, 32'h5);
    wr(4'd6, 32'h0001_0004); rd(4'd5, r); check("R5 clear+set", r, 32'h4);
    wr(4'd6, 32'h0004_0004); rd(4'd5, r); check("R6 set wins", r, 32'h4);
    wr(4'd6, 32'h0004_0000); check("R5 clear pad", {16'h0, pad_out}, 32'h0);

    // R7 synchronizer latency
    @(negedge clk); pad_in = 16'hA55A;
    rd(4'd4, r); check("R7 too early", r, 32'h0);
    rd(4'd4, r); check("R7 arrived", r, 32'h0000_A55A);

    // R10 aborted series
    wr(4'd0, 32'h0);
    wr(4'd7, 32'h0001_0001); wr(4'd7, 32'h0000_0002); wr(4'd7, 32'h0001_0001);
    rd(4'd7, r); rd(4'd7, r); check("R10 mismatch/early read", r, 32'h0000_0001);
    wr(4'd7, 32'h0001_0003); wr(4'd7, 32'h0000_0003); rd(4'd7, r);
    wr(4'd7, 32'h0001_0003); rd(4'd7, r); rd(4'd7, r);
    check("R10 out of order", r, 32'h0000_0003);
    wr(4'd0, 32'h0000_0005); rd(4'd0, r); check("R10 still writable", r, 32'h5);

    // R8 full series
    wr(4'd0, 32'h0); wr(4'd1, 32'h0);
    wr(4'd7, 32'h0001_0003); wr(4'd7, 32'h0000_0003); wr(4'd7, 32'h0001_0003);
    rd(4'd7, r); check("R8 final read", r, 32'h0000_0003);
    rd(4'd7, r); check("R8 active", r, 32'h0001_0003);

    // R9 locked behaviour
    wr(4'd0, 32'hFFFF_FFFF); rd(4'd0, r); check("R9 mode", r, 32'hFFFF_FFF0);
    wr(4'd1, 32'hFFFF_FFFF); rd(4'd1, r); check("R9 otype", r, 32'h0000_FFFC);
    wr(4'd7, 32'h0000_0000); rd(4'd7, r); check("R9 lock write ignored", r, 32'h0001_0003);
    wr(4'd5, 32'h0000_0003); rd(4'd5, r); check("R9 odr writable", r, 32'h3);
    wr(4'd6, 32'h0001_0000); rd(4'd5, r); check("R9 setclr writable", r, 32'h2);

    // R1 reset clears lock
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    rd(4'd7, r); check("R1 lock after reset", r, 32'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule